// File: doc/BRIEF.md
# Predicated Vector-to-Tile Accumulator

The block keeps a square storage array whose side equals the vector length in bytes, with one physical row per vector byte. The array is divided into tiles. A start pulse asks the block to add one source vector into one tile. Each addition is governed by two predicate masks. One mask selects tile rows and the other selects tile columns.

In row-wise mode, every enabled row receives the vector element by element. In column-wise mode, every enabled row `r` receives source element `r`, repeated across its enabled columns. Elements may be 32 or 64 bits wide. The tiles are interleaved row by row in the shared array. The block processes one tile row per clock. When the operation completes, it raises a one-cycle completion pulse. A combinational read port returns any whole physical row.

Top module: `adda_tile_acc`

## Requirements
- R1: With `accMode`=0 (row-wise), tile element [r][c] becomes [r][c] + source element c wherever both the row predicate of r and the column predicate of c are set.
- R2: With `accMode`=1 (column-wise), tile element [r][c] becomes [r][c] + source element r under the same row-and-column predicate condition.
- R3: For `elemSize`=0 (32-bit), the predicate bit governing element i is bit 4*i. For `elemSize`=1 (64-bit), it is bit 8*i. No other predicate bit has any effect, and an element with an inactive predicate keeps its value exactly.
- R4: A tile row or column holds VL_BITS/32 elements for 32-bit size and VL_BITS/64 elements for 64-bit size. At the default 128 bits this gives 4x4 and 2x2. Element c of a physical row occupies bits [w*c+w-1 : w*c], where w is the element width.
- R5: Row r of tile t is stored at physical row r*N+t. N is 4 for 32-bit size, where only `tile[1:0]` is used. N is 8 for 64-bit size, where all of `tile[2:0]` is used. Rows outside the chosen tile are left untouched.
- R6: Suppose start is sampled at clock edge k. Then `busy` is high after edge k, one tile row is written per edge from k+1 to k+E, and `done` is high for exactly the one cycle after edge k+E. E is the element count from R4.
- R7: A start pulse while `busy` is high is ignored. A start pulse in the cycle where `done` is high is accepted.
- R8: A synchronous reset clears every array row to zero and drops `busy` and `done`.
- R9: `rdData` shows physical row `rdAddr` combinationally, and holds still while the address is stable and no row is written.
- R10: Additions wrap modulo 2^32 or 2^64 according to element size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an accumulation (ignored while busy) |
| accMode | input | 1 | 0 row-wise, 1 column-wise |
| elemSize | input | 1 | 0 for 32-bit, 1 for 64-bit elements |
| tile | input | 3 | Tile number (bit 2 unused for 32-bit) |
| srcVec | input | VL_BITS | Source vector |
| rowPred | input | VL_BITS/8 | Row predicate, one bit per byte |
| colPred | input | VL_BITS/8 | Column predicate, one bit per byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rdAddr | input | log2(VL_BITS/8) | Physical row to read |
| rdData | output | VL_BITS | Contents of the addressed row |

## Verification
Two events can fall in the same cycle: the completion pulse of one accumulation and the start of the next. The bench launches a second operation exactly in the `done` cycle. It then checks that the new `done` arrives E cycles later and that both sums appear in the array. The opposite case is a start issued in the cycle after acceptance, while the first rows are being written. The bench confirms that this start leaves no trace: there is no extra `done`, and every array row matches a model that applied only the first operation.

// File: rtl/adda_pkg.sv
package adda_pkg;

  typedef enum logic {
    ACC_ROWWISE = 1'b0,
    ACC_COLWISE = 1'b1
  } accMode_e;

  typedef enum logic {
    ELEM_W32 = 1'b0,
    ELEM_W64 = 1'b1
  } elemSize_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch operands this edge
    logic writeEn;   // write one tile row this edge
    logic lastRow;   // current row is the final one
  } ctlStrobe_t;

endpackage

// File: rtl/adda_ctrl.sv
module adda_ctrl
  import adda_pkg::*;
#(
  parameter int VL_BITS = 128,
  localparam int VBYTES = VL_BITS / 8,
  localparam int ELEMS32 = VBYTES / 4,
  localparam int ELEMS64 = VBYTES / 8,
  localparam int IDX_W = $clog2(ELEMS32)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             elemSize,
  output ctlStrobe_t       ctlStb,
  output logic [IDX_W-1:0] rowIdx,
  output logic             busy,
  output logic             done
);

  logic             busyQ;
  logic             doneQ;
  logic             sizeQ;
  logic [IDX_W-1:0] rowQ;
  logic             accept;
  logic             atLast;

  assign accept = start && !busyQ;
  assign atLast = (sizeQ == ELEM_W64) ? (rowQ == IDX_W'(ELEMS64 - 1))
                                      : (rowQ == IDX_W'(ELEMS32 - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busyQ <= 1'b0;
      doneQ <= 1'b0;
      sizeQ <= 1'b0;
      rowQ  <= '0;
    end else begin
      doneQ <= 1'b0;
      if (accept) begin
        busyQ <= 1'b1;
        rowQ  <= '0;
        sizeQ <= elemSize;
      end else if (busyQ) begin
        if (atLast) begin
          busyQ <= 1'b0;
          doneQ <= 1'b1;
        end else begin
          rowQ <= rowQ + 1'b1;
        end
      end
    end
  end

  always_comb begin
    ctlStb.capture = accept;
    ctlStb.writeEn = busyQ;
    ctlStb.lastRow = busyQ && atLast;
  end

  assign rowIdx = rowQ;
  assign busy   = busyQ;
  assign done   = doneQ;

endmodule

// File: rtl/adda_datapath.sv
module adda_datapath
  import adda_pkg::*;
#(
  parameter int VL_BITS = 128,
  localparam int VBYTES = VL_BITS / 8,
  localparam int ROWS = VBYTES,
  localparam int ROW_AW = $clog2(ROWS),
  localparam int ELEMS32 = VBYTES / 4,
  localparam int ELEMS64 = VBYTES / 8,
  localparam int IDX_W = $clog2(ELEMS32)
) (
  input  logic               clk,
  input  logic               rst,
  input  ctlStrobe_t         ctlStb,
  input  logic [IDX_W-1:0]   rowIdx,
  input  logic               accMode,
  input  logic               elemSize,
  input  logic [2:0]         tile,
  input  logic [VL_BITS-1:0] srcVec,
  input  logic [VBYTES-1:0]  rowPred,
  input  logic [VBYTES-1:0]  colPred,
  input  logic [ROW_AW-1:0]  rdAddr,
  output logic [VL_BITS-1:0] rdData,
  output logic [ROW_AW-1:0]  wrAddr
);

  logic               opMode;
  logic               opSize;
  logic [2:0]         opTile;
  logic [VL_BITS-1:0] opVec;
  logic [VBYTES-1:0]  opRowPred;
  logic [VBYTES-1:0]  opColPred;

  logic [VL_BITS-1:0] tileMem [ROWS];

  always_ff @(posedge clk) begin
    if (rst) begin
      opMode    <= 1'b0;
      opSize    <= 1'b0;
      opTile    <= '0;
      opVec     <= '0;
      opRowPred <= '0;
      opColPred <= '0;
    end else if (ctlStb.capture) begin
      opMode    <= accMode;
      opSize    <= elemSize;
      opTile    <= tile;
      opVec     <= srcVec;
      opRowPred <= rowPred;
      opColPred <= colPred;
    end
  end

  // interleaved tile addressing: row r of tile t sits at r*N + t
  always_comb begin
    if (opSize == ELEM_W64)
      wrAddr = (ROW_AW'(rowIdx) << 3) | ROW_AW'(opTile);
    else
      wrAddr = (ROW_AW'(rowIdx) << 2) | ROW_AW'(opTile[1:0]);
  end

  // governing predicate bits at element spacing
  logic [ELEMS32-1:0] rowOn32, colOn32;
  logic [ELEMS64-1:0] rowOn64, colOn64;
  logic [31:0]        src32 [ELEMS32];
  logic [63:0]        src64 [ELEMS64];

  for (genvar i = 0; i < ELEMS32; i++) begin : g_pick32
    assign rowOn32[i] = opRowPred[4*i];
    assign colOn32[i] = opColPred[4*i];
    assign src32[i]   = opVec[32*i +: 32];
  end

  for (genvar i = 0; i < ELEMS64; i++) begin : g_pick64
    assign rowOn64[i] = opRowPred[8*i];
    assign colOn64[i] = opColPred[8*i];
    assign src64[i]   = opVec[64*i +: 64];
  end

  logic [VL_BITS-1:0] oldRow;
  logic [VL_BITS-1:0] newRow32;
  logic [VL_BITS-1:0] newRow64;
  logic [VL_BITS-1:0] newRow;
  logic               rowEn32;
  logic               rowEn64;
  logic [31:0]        colSrc32;
  logic [63:0]        colSrc64;

  assign oldRow   = tileMem[wrAddr];
  assign rowEn32  = rowOn32[rowIdx];
  assign rowEn64  = rowOn64[rowIdx[IDX_W-2:0]];
  assign colSrc32 = src32[rowIdx];
  assign colSrc64 = src64[rowIdx[IDX_W-2:0]];

  for (genvar c = 0; c < ELEMS32; c++) begin : g_lane32
    logic [31:0] addend32;
    logic [31:0] sum32;
    assign addend32 = (opMode == ACC_COLWISE) ? colSrc32 : src32[c];
    assign sum32    = oldRow[32*c +: 32] + addend32;
    assign newRow32[32*c +: 32] = (rowEn32 && colOn32[c]) ? sum32
                                                          : oldRow[32*c +: 32];
  end

  for (genvar c = 0; c < ELEMS64; c++) begin : g_lane64
    logic [63:0] addend64;
    logic [63:0] sum64;
    assign addend64 = (opMode == ACC_COLWISE) ? colSrc64 : src64[c];
    assign sum64    = oldRow[64*c +: 64] + addend64;
    assign newRow64[64*c +: 64] = (rowEn64 && colOn64[c]) ? sum64
                                                          : oldRow[64*c +: 64];
  end

  assign newRow = (opSize == ELEM_W64) ? newRow64 : newRow32;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < ROWS; r++) tileMem[r] <= '0;
    end else if (ctlStb.writeEn) begin
      tileMem[wrAddr] <= newRow;
    end
  end

  assign rdData = tileMem[rdAddr];

endmodule

// File: rtl/adda_tile_acc.sv
module adda_tile_acc
  import adda_pkg::*;
#(
  parameter int VL_BITS = 128,
  localparam int VBYTES = VL_BITS / 8,
  localparam int ROW_AW = $clog2(VBYTES),
  localparam int IDX_W = $clog2(VBYTES / 4)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               accMode,
  input  logic               elemSize,
  input  logic [2:0]         tile,
  input  logic [VL_BITS-1:0] srcVec,
  input  logic [VBYTES-1:0]  rowPred,
  input  logic [VBYTES-1:0]  colPred,
  output logic               busy,
  output logic               done,
  input  logic [ROW_AW-1:0]  rdAddr,
  output logic [VL_BITS-1:0] rdData
);

  ctlStrobe_t        ctlStb;
  logic [IDX_W-1:0]  rowIdx;
  logic [ROW_AW-1:0] wrAddr;

  adda_ctrl #(.VL_BITS(VL_BITS)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .elemSize (elemSize),
    .ctlStb   (ctlStb),
    .rowIdx   (rowIdx),
    .busy     (busy),
    .done     (done)
  );

  adda_datapath #(.VL_BITS(VL_BITS)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctlStb   (ctlStb),
    .rowIdx   (rowIdx),
    .accMode  (accMode),
    .elemSize (elemSize),
    .tile     (tile),
    .srcVec   (srcVec),
    .rowPred  (rowPred),
    .colPred  (colPred),
    .rdAddr   (rdAddr),
    .rdData   (rdData),
    .wrAddr   (wrAddr)
  );

endmodule

// File: rtl/adda_tile_acc_chk.sv
module adda_tile_acc_chk #(
  parameter int VL_BITS = 128,
  localparam int VBYTES = VL_BITS / 8,
  localparam int ROW_AW = $clog2(VBYTES),
  localparam int ELEMS32 = VBYTES / 4,
  localparam int ELEMS64 = VBYTES / 8
) (
  input logic               clk,
  input logic               rst,
  input logic               start,
  input logic               elemSize,
  input logic [2:0]         tile,
  input logic               busy,
  input logic               done,
  input logic               wrEn,
  input logic               lastRow,
  input logic [ROW_AW-1:0]  wrAddr,
  input logic [ROW_AW-1:0]  rdAddr,
  input logic [VL_BITS-1:0] rdData
);

  logic       sizeQ;
  logic [2:0] tileQ;
  logic [15:0] rowCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sizeQ  <= 1'b0;
      tileQ  <= '0;
      rowCnt <= '0;
    end else if (start && !busy) begin
      sizeQ  <= elemSize;
      tileQ  <= tile;
      rowCnt <= '0;
    end else if (wrEn) begin
      rowCnt <= rowCnt + 1'b1;
    end
  end

  // R6: completion is a single-cycle pulse
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6: completion follows the final row write
  p_done_after_last_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(wrEn && lastRow));

  // R6/R7: exactly E rows written for the accepted operation
  p_row_count_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> (rowCnt == (sizeQ ? 16'(ELEMS64) : 16'(ELEMS32))));

  // R5: writes land only on rows of the tile latched at acceptance
  p_tile_lane_r5: assert property (@(posedge clk) disable iff (rst)
    wrEn |-> (sizeQ ? (wrAddr[2:0] == tileQ) : (wrAddr[1:0] == tileQ[1:0])));

  // R9: read data is stable without writes or address changes
  p_read_stable_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wrEn) && $stable(rdAddr)) |-> $stable(rdData));

  // R8: array reads as zero right after reset
  p_reset_clear_r8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rdData == '0 && !busy && !done));

endmodule

bind adda_tile_acc adda_tile_acc_chk #(.VL_BITS(VL_BITS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .elemSize (elemSize),
  .tile     (tile),
  .busy     (busy),
  .done     (done),
  .wrEn     (ctlStb.writeEn),
  .lastRow  (ctlStb.lastRow),
  .wrAddr   (wrAddr),
  .rdAddr   (rdAddr),
  .rdData   (rdData)
);

// File: tb/adda_tile_acc_bench.sv
`timescale 1ns/10ps
module adda_tile_acc_bench;

  typedef struct packed {
    logic         mode;
    logic         size;
    logic [2:0]   tile;
    logic [127:0] vec;
    logic [15:0]  pr;
    logic [15:0]  pc;
  } opT;

  localparam int NOPS = 9;
  localparam opT OPS [NOPS] = '{
    // R1 row-wise 32-bit, all enabled, tile 0
    '{1'b0, 1'b0, 3'd0, 128'h00000004_00000003_00000002_00000001, 16'hFFFF, 16'hFFFF},
    // R2 column-wise 32-bit, tile 1, cols 0..1
    '{1'b1, 1'b0, 3'd1, 128'h00000040_00000030_00000020_00000010, 16'h1111, 16'h0011},
    // R3 sparse rows 0,2 cols 1,3, tile 2
    '{1'b0, 1'b0, 3'd2, 128'h00000700_00000500_00000300_00000100, 16'h0101, 16'h1010},
    // R3 only non-governing bits set: no change, tile 3
    '{1'b0, 1'b0, 3'd3, 128'h11111111_22222222_33333333_44444444, 16'hEEEE, 16'hFFFF},
    // R4 row-wise 64-bit, tile 5, rows 0,1 col 0
    '{1'b0, 1'b1, 3'd5, 128'h00000000_00000007_00000000_00000005, 16'h0101, 16'h0001},
    // R2 column-wise 64-bit, tile 7, row 1 both cols
    '{1'b1, 1'b1, 3'd7, 128'h00000000_00000900_00000000_00000800, 16'h0100, 16'h0101},
    // R5 tile bit 2 ignored in 32-bit: acts on tile 2
    '{1'b0, 1'b0, 3'd6, 128'h00050000_00040000_00030000_00020000, 16'hFFFF, 16'hFFFF},
    // R10 32-bit wrap on tile 0
    '{1'b0, 1'b0, 3'd0, {4{32'hFFFFFFFF}}, 16'hFFFF, 16'hFFFF},
    // R10/R5 64-bit wrap on tile 0 sharing rows with 32-bit tile 0
    '{1'b0, 1'b1, 3'd0, {2{64'hFFFFFFFFFFFFFFF0}}, 16'h0101, 16'h0101}
  };

  function automatic string tagOf(input int i);
    case (i)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R3";
      4: return "R4";
      5: return "R2";
      6: return "R5";
      default: return "R10";
    endcase
  endfunction

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         accMode = 1'b0;
  logic         elemSize = 1'b0;
  logic [2:0]   tile = '0;
  logic [127:0] srcVec = '0;
  logic [15:0]  rowPred = '0;
  logic [15:0]  colPred = '0;
  logic         busy;
  logic         done;
  logic [3:0]   rdAddr = '0;
  logic [127:0] rdData;

  int checks = 0;
  int fails = 0;
  logic [127:0] model [16];

  always #2.5 clk = ~clk;

  adda_tile_acc u_adda_tile_acc (
    .clk(clk), .rst(rst), .start(start), .accMode(accMode),
    .elemSize(elemSize), .tile(tile), .srcVec(srcVec),
    .rowPred(rowPred), .colPred(colPred), .busy(busy), .done(done),
    .rdAddr(rdAddr), .rdData(rdData)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void applyModel(input opT o);
    if (!o.size) begin
      for (int r = 0; r < 4; r++)
        for (int c = 0; c < 4; c++)
          if (o.pr[4*r] && o.pc[4*c]) begin
            int p = r*4 + int'(o.tile[1:0]);
            model[p][32*c +: 32] = model[p][32*c +: 32] +
              (o.mode ? o.vec[32*r +: 32] : o.vec[32*c +: 32]);
          end
    end else begin
      for (int r = 0; r < 2; r++)
        for (int c = 0; c < 2; c++)
          if (o.pr[8*r] && o.pc[8*c]) begin
            int p = r*8 + int'(o.tile);
            model[p][64*c +: 64] = model[p][64*c +: 64] +
              (o.mode ? o.vec[64*r +: 64] : o.vec[64*c +: 64]);
          end
    end
  endfunction

  // called at a negedge; leaves off at the negedge after acceptance
  task automatic launch(input opT o);
    accMode = o.mode; elemSize = o.size; tile = o.tile;
    srcVec = o.vec; rowPred = o.pr; colPred = o.pc;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone(input int e, input string req);
    for (int i = 1; i <= e; i++) begin
      @(negedge clk);
      chk(done == (i == e), req, 128'(done), 128'(i == e));
    end
  endtask

  task automatic checkArray(input string req);
    for (int r = 0; r < 16; r++) begin
      rdAddr = 4'(r);
      #0.1;
      chk(rdData === model[r], req, rdData, model[r]);
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int r = 0; r < 16; r++) model[r] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    chk(busy == 1'b0 && done == 1'b0, "R8", 128'({busy, done}), 128'(0));
    checkArray("R8");

    // table walk: R1..R5, R10, with R6 timing on each
    for (int i = 0; i < NOPS; i++) begin
      @(negedge clk);
      launch(OPS[i]);
      chk(busy == 1'b1, "R6", 128'(busy), 128'(1));
      waitDone(OPS[i].size ? 2 : 4, "R6");
      applyModel(OPS[i]);
      @(negedge clk);
      checkArray(tagOf(i));
    end

    // R7: start while busy is ignored
    begin
      opT a, b;
      a = '{1'b0, 1'b0, 3'd1, 128'h00000001_00000001_00000001_00000001, 16'hFFFF, 16'hFFFF};
      b = '{1'b0, 1'b0, 3'd3, 128'h0000AAAA_0000AAAA_0000AAAA_0000AAAA, 16'hFFFF, 16'hFFFF};
      @(negedge clk);
      launch(a);
      accMode = b.mode; elemSize = b.size; tile = b.tile;
      srcVec = b.vec; rowPred = b.pr; colPred = b.pc;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int i = 2; i <= 4; i++) begin
        @(negedge clk);
        chk(done == (i == 4), "R7", 128'(done), 128'(i == 4));
      end
      applyModel(a);
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R7", 128'({busy, done}), 128'(0));
      end
      checkArray("R7");
    end

    // R7: back-to-back start in the done cycle
    begin
      opT a, c;
      a = '{1'b1, 1'b1, 3'd4, 128'h00000000_00000002_00000000_00000003, 16'hFFFF, 16'hFFFF};
      c = '{1'b1, 1'b0, 3'd0, 128'h00000008_00000006_00000004_00000002, 16'h1011, 16'h0111};
      @(negedge clk);
      launch(a);
      waitDone(2, "R7");
      launch(c);
      waitDone(4, "R7");
      applyModel(a);
      applyModel(c);
      @(negedge clk);
      checkArray("R7");
    end

    // R8: reset in the middle of an operation
    begin
      opT a;
      a = '{1'b0, 1'b0, 3'd2, {4{32'h12345678}}, 16'hFFFF, 16'hFFFF};
      @(negedge clk);
      launch(a);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      for (int r = 0; r < 16; r++) model[r] = '0;
      chk(busy == 1'b0 && done == 1'b0, "R8", 128'({busy, done}), 128'(0));
      checkArray("R8");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule